// File: doc/BRIEF.md
# AES-128 Coprocessor with Chained Block Loading

This block is a memory-mapped AES-128 engine behind a byte-wide register port. Software or a DMA engine fills a 16-byte key memory and a 16-byte state memory one byte at a time, then requests an encryption or a decryption. An iterative datapath runs one full round per clock. The sequencer pads the run to a fixed latency, so software and DMA always see the same completion time. On completion the block sets a done flag, can raise an interrupt, and pulses a DMA trigger. The result is then read back through the same data register.

For cipher block chaining, an XOR load mode folds each written byte into the byte already stored at that position. Writing the next plaintext over the previous ciphertext therefore leaves their XOR in the state memory. An auto-start mode launches the operation once all 16 state bytes have arrived, so a DMA engine can stream blocks without a separate start write. After an encryption the key memory holds the last round key. A decryption starts from that key, rebuilds the earlier round keys by running the key expansion backwards, and ends with the original key in the key memory.

Register map (`addr_i`): 0 = control, 1 = status, 2 = state data, 3 = key data.

Top module: `aes_cp`

## Requirements
- R1: An encryption of the state memory under the key memory leaves the ciphertext in the state memory. Reading address 2 returns it byte 0 first, where byte 0 is the first byte of the block as it appears on the wire.
- R2: After an encryption, reading address 3 returns the final (tenth) round key, byte 0 first.
- R3: A decryption (control bit 1 set when the operation starts) with the final round key in the key memory returns the plaintext in the state memory and leaves the original cipher key in the key memory.
- R4: Status bit 0 (done) rises exactly 375 clock edges after the edge that accepts the start, and status bit 7 (busy) is set for the cycles in between.
- R5: `irq_o` is high exactly while done is set and control bit 4 (interrupt enable) is set.
- R6: `dma_trig_o` is a single-cycle pulse that rises on the same edge as done.
- R7: While control bit 2 (XOR load) is set, a write to address 2 stores the XOR of the written byte and the stored byte at the current position.
- R8: While control bit 3 (auto-start) is set, the operation starts on the edge after the 16th accepted state write counted since the last start or pointer reset.
- R9: The state and key pointers are 4 bits wide. Each advances on every read and every accepted write of its data register and wraps from 15 to 0. Both clear on a start and on a control write with bit 5 set.
- R10: A start request (control bit 0) or a data or key write while busy sets status bit 1 (error) and has no other effect.
- R11: Writing 1 to status bit 0 or bit 1 clears done or error respectively. A new start also clears done.
- R12: After reset every register reads zero, and both `irq_o` and `dma_trig_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register select: 0 control, 1 status, 2 state data, 3 key data |
| wr_i | input | 1 | Write strobe for the selected register |
| rd_i | input | 1 | Read strobe; advances the data or key pointer |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Interrupt request, level |
| dma_trig_o | output | 1 | One-cycle DMA trigger on completion |

## Verification
Done, busy, the interrupt level and the DMA pulse are all due a fixed number of edges after the accepted start. For a start written through the control register that is 375 edges. For auto-start it is 376 edges after the 16th state write, because the launch edge comes first. A behavioural model in the bench advances one step per clock edge from the same bus traffic and predicts the interrupt and trigger outputs, which are compared at every falling edge. The status register is sampled at falling edges 374 and 375 after a start to pin the done edge exactly. Data results are checked against published AES-128 vectors and their last round keys, read back through the byte pointers.

// File: rtl/aes_cp_pkg.sv
package aes_cp_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_KEY  = 2'd3;
  localparam int C_GO = 0, C_DEC = 1, C_XOR = 2, C_AUTO = 3, C_IRQ = 4, C_PRST = 5;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
    logic [15:0] d;
    d = {a, a} << n;
    return d[15:8];
  endfunction

  // a^254 by repeated squaring; maps 0 to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] x, r;
    x = a;
    r = 8'h01;
    for (int i = 0; i < 7; i++) begin
      x = gmul(x, x);
      r = gmul(r, x);
    end
    return r;
  endfunction

  function automatic logic [7:0] fwd_sub(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] inv_sub(input logic [7:0] a);
    return gf_inv(rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05);
  endfunction

  function automatic logic [7:0] rcon(input logic [3:0] r);
    logic [7:0] v;
    v = 8'h01;
    for (int i = 1; i < 10; i++)
      if (i < int'(r)) v = xtime(v);
    return v;
  endfunction

  function automatic logic [31:0] mix_col(input logic [31:0] c, input logic inv);
    logic [7:0] a [4];
    logic [7:0] m0, m1, m2, m3;
    logic [31:0] r;
    for (int i = 0; i < 4; i++) a[i] = c[8*i +: 8];
    {m0, m1, m2, m3} = inv ? {8'd14, 8'd11, 8'd13, 8'd9} : {8'd2, 8'd3, 8'd1, 8'd1};
    for (int i = 0; i < 4; i++)
      r[8*i +: 8] = gmul(a[i], m0) ^ gmul(a[(i+1)%4], m1) ^
                    gmul(a[(i+2)%4], m2) ^ gmul(a[(i+3)%4], m3);
    return r;
  endfunction
endpackage

// File: rtl/aes_cp_sbox.sv
module aes_cp_sbox
  import aes_cp_pkg::*;
#(
  parameter bit INV = 1'b0
) (
  input  logic [7:0] a_i,
  output logic [7:0] y_o
);
  if (INV) begin : g_inv
    assign y_o = inv_sub(a_i);
  end else begin : g_fwd
    assign y_o = fwd_sub(a_i);
  end
endmodule

// File: rtl/aes_cp_round.sv
module aes_cp_round
  import aes_cp_pkg::*;
(
  input  logic [127:0] st_i,
  input  logic [127:0] rk_i,
  input  logic         dec_i,
  input  logic         last_i,
  input  logic [7:0]   rcon_i,
  output logic [127:0] st_o,
  output logic [127:0] rk_o
);
  logic [127:0] sh_f, sh_b, sb_f, sb_b, mc_f, mc_b, ak_b;
  logic [127:0] rk_f, rk_b;
  logic [31:0]  kw, kb, t;

  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign sh_f[8*(r+4*c) +: 8] = st_i[8*(r+4*((c+r)%4)) +: 8];
      assign sh_b[8*(r+4*c) +: 8] = st_i[8*(r+4*((c+4-r)%4)) +: 8];
    end
    assign mc_f[32*c +: 32] = mix_col(sb_f[32*c +: 32], 1'b0);
    assign mc_b[32*c +: 32] = mix_col(ak_b[32*c +: 32], 1'b1);
  end

  for (genvar b = 0; b < 16; b++) begin : g_sb
    aes_cp_sbox #(.INV(1'b0)) u_fwd (.a_i(sh_f[8*b +: 8]), .y_o(sb_f[8*b +: 8]));
    aes_cp_sbox #(.INV(1'b1)) u_inv (.a_i(sh_b[8*b +: 8]), .y_o(sb_b[8*b +: 8]));
  end

  // last word of the key, recovered first when stepping backwards
  assign kw = dec_i ? (rk_i[127:96] ^ rk_i[95:64]) : rk_i[127:96];

  for (genvar b = 0; b < 4; b++) begin : g_ks
    aes_cp_sbox #(.INV(1'b0)) u_ks (.a_i(kw[8*b +: 8]), .y_o(kb[8*b +: 8]));
  end

  assign t = {kb[7:0], kb[31:24], kb[23:16], kb[15:8] ^ rcon_i};

  always_comb begin
    logic [31:0] n0, n1, n2, n3;
    n0 = rk_i[31:0] ^ t;
    n1 = rk_i[63:32] ^ n0;
    n2 = rk_i[95:64] ^ n1;
    n3 = rk_i[127:96] ^ n2;
    rk_f = {n3, n2, n1, n0};
    rk_b = {rk_i[127:96] ^ rk_i[95:64], rk_i[95:64] ^ rk_i[63:32],
            rk_i[63:32] ^ rk_i[31:0], rk_i[31:0] ^ t};
  end

  assign ak_b = sb_b ^ rk_b;

  always_comb begin
    if (dec_i) begin
      st_o = last_i ? ak_b : mc_b;
      rk_o = rk_b;
    end else begin
      st_o = (last_i ? sb_f : mc_f) ^ rk_f;
      rk_o = rk_f;
    end
  end
endmodule

// File: rtl/aes_cp_seq.sv
module aes_cp_seq #(
  parameter int LATENCY = 375,
  localparam int CW = $clog2(LATENCY)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic [CW-1:0] step_o,
  output logic          fin_o,
  output logic          trig_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q, trig_q;

  assign fin_o  = busy_q && (cnt_q == CW'(LATENCY - 1));
  assign busy_o = busy_q;
  assign step_o = cnt_q;
  assign trig_o = trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= fin_o;
      if (start_i) begin
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (fin_o) begin
          cnt_q  <= '0;
          busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_step_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (int'(cnt_q) < LATENCY));
endmodule

// File: rtl/aes_cp.sv
module aes_cp
  import aes_cp_pkg::*;
#(
  parameter int LATENCY = 375
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  output logic       dma_trig_o
);
  localparam int NBYTE  = 16;
  localparam int PW     = $clog2(NBYTE);
  localparam int CW     = $clog2(LATENCY);
  localparam int NROUND = 10;
  localparam int LW     = $clog2(LATENCY + 1) + 1;

  logic [127:0]  st_q, key_q, r_st, r_rk;
  logic [PW-1:0] sptr_q, kptr_q;
  logic [PW:0]   fill_q;
  logic          dec_q, xor_q, auto_q, irq_en_q, done_q, err_q;
  logic          busy, fin, start, go_req, auto_go, prst, in_round, last;
  logic [CW-1:0] step;
  logic [3:0]    rnd;

  wire wr_ctrl = wr_i && (addr_i == A_CTRL);
  wire wr_stat = wr_i && (addr_i == A_STAT);
  wire wr_data = wr_i && (addr_i == A_DATA);
  wire wr_key  = wr_i && (addr_i == A_KEY);

  assign go_req   = wr_ctrl && wdata_i[C_GO];
  assign auto_go  = auto_q && (fill_q == (PW+1)'(NBYTE)) && !busy;
  assign start    = (go_req && !busy) || auto_go;
  assign prst     = wr_ctrl && !busy && wdata_i[C_PRST];
  assign in_round = busy && (step != '0) && (step <= CW'(NROUND));
  assign last     = (step == CW'(NROUND));
  assign rnd      = dec_q ? 4'(NROUND + 1 - int'(step)) : step[3:0];

  aes_cp_seq #(.LATENCY(LATENCY)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .busy_o(busy), .step_o(step),
    .fin_o(fin), .trig_o(dma_trig_o)
  );

  aes_cp_round u_round (
    .st_i(st_q), .rk_i(key_q), .dec_i(dec_q), .last_i(last),
    .rcon_i(rcon(rnd)), .st_o(r_st), .rk_o(r_rk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {dec_q, xor_q, auto_q, irq_en_q, done_q, err_q} <= '0;
    end else begin
      if (wr_ctrl && !busy) begin
        dec_q    <= wdata_i[C_DEC];
        xor_q    <= wdata_i[C_XOR];
        auto_q   <= wdata_i[C_AUTO];
        irq_en_q <= wdata_i[C_IRQ];
      end
      if (start)                      done_q <= 1'b0;
      else if (fin)                   done_q <= 1'b1;
      else if (wr_stat && wdata_i[0]) done_q <= 1'b0;
      if (busy && (wr_data || wr_key || go_req)) err_q <= 1'b1;
      else if (wr_stat && wdata_i[1])            err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      key_q <= '0;
    end else if (busy) begin
      if (step == '0) begin
        st_q <= st_q ^ key_q;
      end else if (in_round) begin
        st_q  <= r_st;
        key_q <= r_rk;
      end
    end else begin
      if (wr_data) st_q[8*sptr_q +: 8] <= xor_q ? (st_q[8*sptr_q +: 8] ^ wdata_i) : wdata_i;
      if (wr_key)  key_q[8*kptr_q +: 8] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sptr_q <= '0;
      kptr_q <= '0;
      fill_q <= '0;
    end else if (start || prst) begin
      sptr_q <= '0;
      kptr_q <= '0;
      fill_q <= '0;
    end else begin
      if (addr_i == A_DATA && (rd_i || (wr_i && !busy))) sptr_q <= sptr_q + 1'b1;
      if (addr_i == A_KEY  && (rd_i || (wr_i && !busy))) kptr_q <= kptr_q + 1'b1;
      if (wr_data && !busy && fill_q != (PW+1)'(NBYTE)) fill_q <= fill_q + 1'b1;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {3'b000, irq_en_q, auto_q, xor_q, dec_q, 1'b0};
      A_STAT:  rdata_o = {busy, 5'b00000, err_q, done_q};
      A_DATA:  rdata_o = st_q[8*sptr_q +: 8];
      default: rdata_o = key_q[8*kptr_q +: 8];
    endcase
  end

  assign irq_o = done_q && irq_en_q;

  // independent cycle count from accepted start to completion
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lat_q <= '0;
    else if (start) lat_q <= '0;
    else if (busy)  lat_q <= lat_q + 1'b1;
  end

  assert_done_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> (lat_q == LW'(LATENCY)));
  assert_trig_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_trig_o |-> done_q);
  assert_trig_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_trig_o |=> !dma_trig_o);
  assert_busy_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && (wr_data || wr_key || go_req)) |=> err_q);
  assert_ptr_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (sptr_q == '0 && kptr_q == '0));
  assert_auto_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_go |=> busy);
endmodule

// File: tb/aes_cp_bench.sv
module aes_cp_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, dma;

  int n_run = 0, n_fail = 0;
  bit model_on = 1'b0;

  always #10 clk = ~clk;

  aes_cp u_aes_cp (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .dma_trig_o(dma)
  );

  localparam logic [127:0] KEY_A = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] PT_A  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] CT_A  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] RK_A  = 128'h13111d7fe3944a17f307a78b4d2b30c5;
  localparam logic [127:0] KEY_B = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] PT_B  = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] CT_B  = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] RK_B  = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;
  localparam logic [127:0] MASK  = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;

  function automatic logic [7:0] bt(input logic [127:0] v, input int i);
    return v[127-8*i -: 8];
  endfunction

  // behavioural model of completion timing, stepped on each rising edge
  int m_cnt = 0, m_fill = 0;
  bit m_done = 0, m_irq = 0, m_auto = 0, m_dma = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_fill = 0; m_done = 0; m_irq = 0; m_auto = 0; m_dma = 0;
    end else begin
      bit busy_pre, go;
      busy_pre = (m_cnt > 0);
      go = m_auto && (m_fill == 16) && !busy_pre;
      m_dma = 0;
      if (wr) begin
        case (addr)
          2'd0: if (!busy_pre) begin
                  m_irq = wdata[4]; m_auto = wdata[3];
                  if (wdata[5]) m_fill = 0;
                  if (wdata[0]) go = 1;
                end
          2'd1: if (wdata[0]) m_done = 0;
          2'd2: if (!busy_pre && m_fill < 16) m_fill++;
          default: ;
        endcase
      end
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin m_done = 1; m_dma = 1; end
      end
      if (go) begin m_cnt = 375; m_done = 0; m_fill = 0; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      n_run++;
      if (irq !== (m_done && m_irq)) begin
        n_fail++;
        $display("FAIL R5 irq_o actual %0b expected %0b at %0t", irq, m_done && m_irq, $time);
      end
      n_run++;
      if (dma !== m_dma) begin
        n_fail++;
        $display("FAIL R6 dma_trig_o actual %0b expected %0b at %0t", dma, m_dma, $time);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #2 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #2 d = rdata;
  endtask

  task automatic load(input logic [1:0] a, input logic [127:0] v);
    for (int i = 0; i < 16; i++) bus_wr(a, bt(v, i));
  endtask

  task automatic expect_block(input logic [1:0] a, input logic [127:0] v, input string req);
    logic [7:0] d;
    for (int i = 0; i < 16; i++) begin
      bus_rd(a, d);
      chk(req, d, bt(v, i));
    end
  endtask

  task automatic wait_done();
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < 500 && !s[0]; i++) begin
      @(negedge clk);
      peek(2'd1, s);
    end
    chk("R4 completion seen", {7'd0, s[0]}, 8'h01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;

    // R12 reset state
    peek(2'd1, d); chk("R12 status after reset", d, 8'h00);
    peek(2'd0, d); chk("R12 control after reset", d, 8'h00);
    peek(2'd2, d); chk("R12 state after reset", d, 8'h00);
    chk("R12 irq_o after reset", {7'd0, irq}, 8'h00);
    chk("R12 dma_trig_o after reset", {7'd0, dma}, 8'h00);

    // encryption with interrupts enabled, plus ignored traffic while busy
    load(2'd3, KEY_A);
    load(2'd2, PT_A);
    bus_wr(2'd0, 8'h11);
    repeat (20) @(negedge clk);
    bus_wr(2'd2, 8'hff);
    bus_wr(2'd3, 8'hff);
    bus_wr(2'd0, 8'h01);
    peek(2'd1, d); chk("R10 error set while busy", d, 8'h82);
    wait_done();
    chk("R5 irq_o with enable", {7'd0, irq}, 8'h01);
    expect_block(2'd2, CT_A, "R1 ciphertext A (R10 writes ignored)");
    expect_block(2'd3, RK_A, "R2 final round key A");
    bus_rd(2'd2, d); chk("R9 pointer wrap", d, bt(CT_A, 0));

    // R11 clear error only
    bus_wr(2'd1, 8'h02);
    peek(2'd1, d); chk("R11 error cleared, done kept", d, 8'h01);

    // decryption with interrupts off, exact latency
    bus_wr(2'd0, 8'h03);
    peek(2'd1, d); chk("R11 start clears done", d, 8'h80);
    repeat (374) @(negedge clk);
    peek(2'd1, d); chk("R4 not done at edge 374", d, 8'h80);
    @(negedge clk);
    peek(2'd1, d); chk("R4 done at edge 375", d, 8'h01);
    chk("R5 irq_o without enable", {7'd0, irq}, 8'h00);
    expect_block(2'd2, PT_A, "R3 plaintext A");
    expect_block(2'd3, KEY_A, "R3 original key A");
    bus_wr(2'd1, 8'h01);
    peek(2'd1, d); chk("R11 done cleared", d, 8'h00);

    // R7 XOR load
    bus_wr(2'd0, 8'h24);
    load(2'd2, MASK);
    expect_block(2'd2, PT_A ^ MASK, "R7 xor load");

    // R8 auto-start of a chained block
    bus_wr(2'd0, 8'h24);
    load(2'd3, KEY_B);
    bus_wr(2'd0, 8'h1c);
    load(2'd2, PT_A ^ MASK ^ PT_B);
    peek(2'd1, d); chk("R8 idle right after 16th write", d, 8'h00);
    @(negedge clk);
    peek(2'd1, d); chk("R8 busy one edge later", d, 8'h80);
    wait_done();
    expect_block(2'd2, CT_B, "R8 ciphertext B");
    expect_block(2'd3, RK_B, "R8 final round key B");

    // R9 pointer reset by control bit
    bus_rd(2'd2, d);
    bus_rd(2'd2, d);
    bus_rd(2'd2, d); chk("R9 third byte", d, bt(CT_B, 2));
    bus_wr(2'd0, 8'h20);
    bus_rd(2'd2, d); chk("R9 pointer reset", d, bt(CT_B, 0));

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule